// File: doc/BRIEF.md
# Variable-Length Instruction Fetch and Field Decoder

This block sits at the front of a multi-cycle processor. It reads one 16-bit instruction word from a synchronous memory port. It then splits that word into its fields and decides from the class and the addressing mode whether a second word must follow. When a second word is needed, the block reads it too. The block hands the finished bundle to the execute stage over a valid/ready handshake.

The bundle holds the class, the opcode, the mode, the operand-select bit, the source and destination register numbers, and a flag for each field that the class actually uses. It also carries the second word, if any, and the address of the first word. A branch that names a register as its target cannot be executed. The block flags such a word with a one-cycle pulse, drops it, and moves on to the next word.

Top module: `insn_fetch_decode`

## Requirements
- R1: While reset is asserted, and after it is released, `dec_valid` and `illegal` are low. The first memory request after reset reads address `RESET_PC`.
- R2: The first word is split as follows: opcode = bits 15:10, mode = bits 9:7, operand select = bit 6, source register = bits 5:3, destination register = bits 2:0.
- R3: The class is bits 15:14. For class 00 no field flag is set. For class 01 and class 11 the mode and destination flags are set and the source flag is clear. For class 10 all three flags are set. The source flag covers both the select bit and the source register.
- R4: A second word is read, and `dec_has_ext` is set, exactly when the class is not 00 and mode bits 2:1 are not 00. The second word is presented on `dec_ext`.
- R5: The program counter steps by one for every word read. `dec_pc` is the address of the first word of the presented instruction, so the next instruction begins right after the last word consumed.
- R6: A word of class 11 with mode bits 2:1 equal to 00 raises `illegal` for exactly one cycle. That word is never presented on `dec_valid`, and fetch resumes at the following address.
- R7: Memory data is taken one cycle after the request. While `dec_valid` is high and `dec_ready` is low, no request is issued and the bundle stays unchanged.
- R8: A bundle is consumed on a cycle in which both `dec_valid` and `dec_ready` are high. Fetch of the next instruction starts in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | 16 | Read data, valid one cycle after the request |
| dec_valid | output | 1 | Decoded bundle available |
| dec_ready | input | 1 | Execute stage accepts the bundle |
| dec_class | output | 2 | Instruction class |
| dec_opcode | output | 6 | Opcode field |
| dec_mode | output | 3 | Addressing mode field |
| dec_sel | output | 1 | Operand-select bit |
| dec_src | output | 3 | Source register number |
| dec_dst | output | 3 | Destination register number |
| dec_mode_vld | output | 1 | Mode field in use |
| dec_src_vld | output | 1 | Select bit and source field in use |
| dec_dst_vld | output | 1 | Destination field in use |
| dec_has_ext | output | 1 | Second word was read |
| dec_ext | output | 16 | Second word |
| dec_pc | output | AW | Address of the first word |
| illegal | output | 1 | One-cycle pulse for a dropped encoding |

## Verification
The assertions assume that the memory returns the addressed word exactly one cycle after each request, with no wait states. They also assume that `dec_ready` is a free input that may be low for any length of time. The bench memory model registers the read data on the request edge, which matches this one-cycle return. The bench drives `dec_ready` only at falling edges and holds it low across a long stall to exercise the hold behaviour.

// File: rtl/insn_fetch_decode.sv
module insn_fetch_decode #(
  parameter int AW = 16,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic [15:0]   mem_rdata,
  output logic          dec_valid,
  input  logic          dec_ready,
  output logic [1:0]    dec_class,
  output logic [5:0]    dec_opcode,
  output logic [2:0]    dec_mode,
  output logic          dec_sel,
  output logic [2:0]    dec_src,
  output logic [2:0]    dec_dst,
  output logic          dec_mode_vld,
  output logic          dec_src_vld,
  output logic          dec_dst_vld,
  output logic          dec_has_ext,
  output logic [15:0]   dec_ext,
  output logic [AW-1:0] dec_pc,
  output logic          illegal
);
  typedef enum logic [2:0] {REQ1, WAIT1, REQ2, WAIT2, HOLD} st_t;

  st_t           st;
  logic [AW-1:0] pc, start_pc;
  logic [15:0]   ir, ext;
  logic          has_ext, err;

  wire [1:0] rd_cls   = mem_rdata[15:14];
  wire       rd_regty = (mem_rdata[9:8] == 2'b00);
  wire       rd_bad   = (rd_cls == 2'b11) && rd_regty;
  wire       rd_ext   = (rd_cls != 2'b00) && !rd_regty;

  assign mem_req  = (st == REQ1) || (st == REQ2);
  assign mem_addr = pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= REQ1;
      pc       <= RESET_PC;
      start_pc <= RESET_PC;
      ir       <= '0;
      ext      <= '0;
      has_ext  <= 1'b0;
      err      <= 1'b0;
    end else begin
      err <= 1'b0;
      case (st)
        REQ1: begin
          start_pc <= pc;
          st       <= WAIT1;
        end
        WAIT1: begin
          pc      <= pc + 1'b1;
          ir      <= mem_rdata;
          has_ext <= rd_ext;
          ext     <= '0;
          if (rd_bad) begin
            err <= 1'b1;
            st  <= REQ1;
          end else if (rd_ext) begin
            st <= REQ2;
          end else begin
            st <= HOLD;
          end
        end
        REQ2:  st <= WAIT2;
        WAIT2: begin
          pc  <= pc + 1'b1;
          ext <= mem_rdata;
          st  <= HOLD;
        end
        HOLD:    if (dec_ready) st <= REQ1;
        default: st <= REQ1;
      endcase
    end
  end

  assign dec_valid    = (st == HOLD);
  assign illegal      = err;
  assign dec_class    = ir[15:14];
  assign dec_opcode   = ir[15:10];
  assign dec_mode     = ir[9:7];
  assign dec_sel      = ir[6];
  assign dec_src      = ir[5:3];
  assign dec_dst      = ir[2:0];
  assign dec_mode_vld = (ir[15:14] != 2'b00);
  assign dec_dst_vld  = (ir[15:14] != 2'b00);
  assign dec_src_vld  = (ir[15:14] == 2'b10);
  assign dec_has_ext  = has_ext;
  assign dec_ext      = ext;
  assign dec_pc       = start_pc;
endmodule

// File: rtl/insn_fetch_decode_chk.sv
module insn_fetch_decode_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          dec_valid,
  input logic          dec_ready,
  input logic [1:0]    dec_class,
  input logic [5:0]    dec_opcode,
  input logic [2:0]    dec_mode,
  input logic          dec_has_ext,
  input logic [15:0]   dec_ext,
  input logic [AW-1:0] dec_pc,
  input logic          illegal
);
  p_illegal_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> !illegal);
  p_illegal_not_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !dec_valid);
  p_branch_not_reg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_class == 2'b11) |-> (dec_mode[2:1] != 2'b00));
  p_ext_rule_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_has_ext == ((dec_class != 2'b00) && (dec_mode[2:1] != 2'b00))));
  p_stall_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |-> !mem_req);
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_pc) && $stable(dec_opcode)
                                   && $stable(dec_ext)));
  p_accept_refetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_ready) |=> (mem_req && !dec_valid));
  p_req_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
endmodule

bind insn_fetch_decode insn_fetch_decode_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .dec_valid(dec_valid),
  .dec_ready(dec_ready), .dec_class(dec_class), .dec_opcode(dec_opcode),
  .dec_mode(dec_mode), .dec_has_ext(dec_has_ext), .dec_ext(dec_ext),
  .dec_pc(dec_pc), .illegal(illegal)
);

// File: tb/insn_fetch_decode_tb_top.sv
module insn_fetch_decode_tb_top;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_rdata = '0;
  logic          dec_valid;
  logic          dec_ready = 1'b0;
  logic [1:0]    dec_class;
  logic [5:0]    dec_opcode;
  logic [2:0]    dec_mode;
  logic          dec_sel;
  logic [2:0]    dec_src, dec_dst;
  logic          dec_mode_vld, dec_src_vld, dec_dst_vld, dec_has_ext;
  logic [15:0]   dec_ext;
  logic [AW-1:0] dec_pc;
  logic          illegal;

  logic [15:0] mem [0:63];
  int n_chk = 0;
  int n_fail = 0;
  int n_illegal = 0;

  always #2.5 clk = ~clk;

  insn_fetch_decode #(.AW(AW), .RESET_PC('0)) dut_i (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_class(dec_class), .dec_opcode(dec_opcode), .dec_mode(dec_mode),
    .dec_sel(dec_sel), .dec_src(dec_src), .dec_dst(dec_dst),
    .dec_mode_vld(dec_mode_vld), .dec_src_vld(dec_src_vld),
    .dec_dst_vld(dec_dst_vld), .dec_has_ext(dec_has_ext), .dec_ext(dec_ext),
    .dec_pc(dec_pc), .illegal(illegal)
  );

  always @(posedge clk) if (mem_req) mem_rdata <= mem[mem_addr[5:0]];
  always @(posedge clk) if (rst_n && illegal) n_illegal <= n_illegal + 1;

  function automatic logic [15:0] mk(logic [5:0] op, logic [2:0] md, logic s,
                                     logic [2:0] sr, logic [2:0] ds);
    return {op, md, s, sr, ds};
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_valid();
    while (!dec_valid) @(negedge clk);
  endtask

  task automatic accept();
    dec_ready = 1'b1;
    @(negedge clk);
    dec_ready = 1'b0;
  endtask

  task automatic expect_bundle(logic [AW-1:0] pc, logic [15:0] w, bit ext_on,
                               logic [15:0] ext_w, bit mv, bit sv, bit dv);
    wait_valid();
    chk(dec_pc == pc, "R5 pc", dec_pc, pc);
    chk(dec_class == w[15:14], "R3 class", dec_class, w[15:14]);
    chk({dec_opcode, dec_mode, dec_sel, dec_src, dec_dst} == w, "R2 fields",
        {dec_opcode, dec_mode, dec_sel, dec_src, dec_dst}, w);
    chk({dec_mode_vld, dec_src_vld, dec_dst_vld} == {mv, sv, dv}, "R3 flags",
        {dec_mode_vld, dec_src_vld, dec_dst_vld}, {mv, sv, dv});
    chk(dec_has_ext == ext_on, "R4 has_ext", dec_has_ext, ext_on);
    if (ext_on) chk(dec_ext == ext_w, "R4 ext word", dec_ext, ext_w);
    accept();
    chk(mem_req && mem_addr == pc + 1 + ext_on, "R8 next fetch", mem_addr, pc + 1 + ext_on);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!dec_valid && !illegal, "R1 outputs in reset", {dec_valid, illegal}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk(mem_req && mem_addr == 0, "R1 first fetch", mem_addr, 0);
    chk(!dec_valid && !illegal, "R1 outputs after reset", {dec_valid, illegal}, 0);
  endtask

  task automatic t_stall();
    logic [AW-1:0] p;
    logic [15:0] e;
    wait_valid();
    p = dec_pc;
    e = dec_ext;
    for (int i = 0; i < 6; i++) begin
      chk(!mem_req, "R7 no fetch in stall", mem_req, 0);
      chk(dec_valid && dec_pc == p && dec_ext == e, "R7 bundle held", dec_pc, p);
      @(negedge clk);
    end
    chk(dec_pc == 9 && dec_ext == 16'h0007, "R7 stalled bundle", dec_ext, 16'h0007);
    accept();
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mem[0]  = mk(6'b000101, 3'b000, 1'b0, 3'd0, 3'd0);
    mem[1]  = mk(6'b010010, 3'b000, 1'b1, 3'd7, 3'd5);
    mem[2]  = mk(6'b010011, 3'b010, 1'b0, 3'd0, 3'd2);
    mem[3]  = 16'hBEEF;
    mem[4]  = mk(6'b100001, 3'b100, 1'b1, 3'd3, 3'd6);
    mem[5]  = 16'h1234;
    mem[6]  = mk(6'b110000, 3'b001, 1'b0, 3'd0, 3'd4);
    mem[7]  = mk(6'b110001, 3'b110, 1'b0, 3'd0, 3'd1);
    mem[8]  = 16'h0042;
    mem[9]  = mk(6'b010100, 3'b011, 1'b0, 3'd0, 3'd3);
    mem[10] = 16'h0007;
    mem[11] = mk(6'b000000, 3'b000, 1'b0, 3'd0, 3'd0);

    t_reset();
    expect_bundle(0, mem[0], 0, 0, 0, 0, 0);
    expect_bundle(1, mem[1], 0, 0, 1, 0, 1);
    expect_bundle(2, mem[2], 1, 16'hBEEF, 1, 0, 1);
    expect_bundle(4, mem[4], 1, 16'h1234, 1, 1, 1);
    // R6: word at 6 is a register-mode branch and must be skipped
    expect_bundle(7, mem[7], 1, 16'h0042, 1, 0, 1);
    chk(n_illegal == 1, "R6 illegal pulse count", n_illegal, 1);
    t_stall();
    expect_bundle(11, mem[11], 0, 0, 0, 0, 0);
    chk(n_illegal == 1, "R6 no extra pulses", n_illegal, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule